// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address front end of a pipelined synchronous burst memory. On a rising clock edge it takes a new word address from the address bus when an address strobe qualifies. There are two active-low strobes. The controller-side strobe loads unconditionally. The processor-side strobe loads only while the active-low chip enable is also low.

After a load, a 2-bit beat counter covers the two least significant address bits. It steps once per edge while the active-low advance input is low, and it holds while advance is high. The upper address bits stay frozen for the whole burst. A static order pin selects one of two offset orders. In linear order the offset is the start offset plus the beat, modulo 4. In interleaved order the offset is the start offset XOR the beat. After four beats the offset wraps back to the start offset.

The output is the full word address for the array. It is valid from the cycle after the capturing edge. The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every input is a plain level sampled on the clock edge, except the order pin. The order pin feeds the output combinationally and must be held static.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and after it is released, before any load, word_addr_o is 0.
- R2: When ctl_strobe_n_i is low on a rising edge, the address is loaded whatever chip_en_n_i is. From the next cycle word_addr_o equals addr_i as sampled.
- R3: When cpu_strobe_n_i is low on a rising edge, the address is loaded only if chip_en_n_i is also low. With chip_en_n_i high, ctl_strobe_n_i high and adv_n_i high, word_addr_o does not change.
- R4: A load always restarts the burst at beat 0, even when adv_n_i is low in the same cycle. A load takes priority over an advance.
- R5: With no load and adv_n_i low on an edge, the beat count rises by one, modulo 4.
- R6: With no load and adv_n_i high on an edge, word_addr_o keeps its value.
- R7: With order_sel_i low (linear), word_addr_o[1:0] = (start[1:0] + beat) mod 4.
- R8: With order_sel_i high (interleaved), word_addr_o[1:0] = start[1:0] XOR beat.
- R9: After four advances the offset returns to the start offset. word_addr_o[AW-1:2] never changes without a load.
- R10: When both strobes qualify in the same cycle, exactly one load of addr_i occurs and the burst starts at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | Word address to capture |
| ctl_strobe_n_i | input | 1 | Controller-side address strobe, active low, not gated |
| cpu_strobe_n_i | input | 1 | Processor-side address strobe, active low, gated by chip enable |
| chip_en_n_i | input | 1 | Chip enable, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| order_sel_i | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| word_addr_o | output | AW | Word address presented to the array |

## Verification
Suppose the captured upper address bits are wrong, or a gated strobe is wrongly accepted. Then word_addr_o shows it on the very next cycle, because nothing but registers lies between capture and output. A beat counter that skips, sticks or fails to restart on a load shows as a wrong low offset one cycle after the faulty edge. A wrong order mapping often matches at beat 0 and only differs from the second beat on. For that reason every burst is walked through all four beats and back to its start in both orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  function automatic logic [BEAT_W-1:0] map_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input burst_order_e      ord
  );
    if (ord == ORDER_INTERLEAVE) return start ^ beat;
    return start + beat;
  endfunction
endpackage

// File: rtl/burst_load_qual.sv
module burst_load_qual (
  input  logic ctl_strobe_n_i,
  input  logic cpu_strobe_n_i,
  input  logic chip_en_n_i,
  output logic load_o
);
  logic cpu_hit;
  logic ctl_hit;

  // processor strobe only counts while chip enable is asserted; it has priority
  assign cpu_hit = ~cpu_strobe_n_i & ~chip_en_n_i;
  assign ctl_hit = ~ctl_strobe_n_i;

  always_comb begin
    if (cpu_hit)      load_o = 1'b1;
    else if (ctl_hit) load_o = 1'b1;
    else              load_o = 1'b0;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          adv_i,
  output logic [BW-1:0] beat_o
);
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     beat_q <= '0;
    else if (load_i) beat_q <= '0;
    else if (adv_i)  beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;

  p_load_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);

  p_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_i) |=> beat_o == BW'($past(beat_o) + 1'b1));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(beat_o));
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= addr_i;
  end

  assign base_o = base_q;

  p_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> base_o == $past(addr_i));

  p_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_o));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          ctl_strobe_n_i,
  input  logic          cpu_strobe_n_i,
  input  logic          chip_en_n_i,
  input  logic          adv_n_i,
  input  logic          order_sel_i,
  output logic [AW-1:0] word_addr_o
);
  localparam int UPPER_W = AW - BEAT_W;

  logic              load;
  logic [BEAT_W-1:0] beat;
  logic [AW-1:0]     base;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel_i);

  burst_load_qual u_qual (
    .ctl_strobe_n_i (ctl_strobe_n_i),
    .cpu_strobe_n_i (cpu_strobe_n_i),
    .chip_en_n_i    (chip_en_n_i),
    .load_o         (load)
  );

  burst_addr_reg #(.AW(AW)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .base_o (base)
  );

  burst_beat_ctr #(.BW(BEAT_W)) u_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .adv_i  (~adv_n_i),
    .beat_o (beat)
  );

  assign word_addr_o = {base[AW-1 -: UPPER_W], map_offset(base[BEAT_W-1:0], beat, order)};

  // first beat after any load presents the captured address in either order
  p_first_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_strobe_n_i || (!cpu_strobe_n_i && !chip_en_n_i)) |=> word_addr_o == $past(addr_i));

  p_gated_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_strobe_n_i && chip_en_n_i && adv_n_i) |=>
      (!$stable(order_sel_i) || $stable(word_addr_o)));

  p_upper_fixed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_strobe_n_i && (cpu_strobe_n_i || chip_en_n_i)) |=>
      $stable(word_addr_o[AW-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ctl_n = 1'b1, cpu_n = 1'b1, ce_n = 1'b1, adv_n = 1'b1, ord = 1'b0;
  logic [AW-1:0] waddr;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .ctl_strobe_n_i(ctl_n), .cpu_strobe_n_i(cpu_n), .chip_en_n_i(ce_n),
    .adv_n_i(adv_n), .order_sel_i(ord), .word_addr_o(waddr)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] off;
    off = ord ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], off};
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: apply inputs, model the edge, push the expected address
  task automatic step(input logic c_n, input logic p_n, input logic e_n,
                      input logic a_n, input logic [AW-1:0] ad, input string tag);
    ctl_n = c_n; cpu_n = p_n; ce_n = e_n; adv_n = a_n; addr = ad;
    @(posedge clk);
    if (!c_n || (!p_n && !e_n)) begin
      m_base = ad; m_beat = '0;
    end else if (!a_n) begin
      m_beat = m_beat + 2'd1;
    end
    exp_q.push_back(model_addr());
    tag_q.push_back(tag);
    #1;
  endtask

  // monitor: compare at the falling edge after each captured edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      automatic logic [AW-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(waddr, e, t);
    end
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(waddr, '0, "R1 in reset");
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(1, 1, 1, 1, 17'h0_0000, "R1 after reset");

    // linear order, load with advance low: load wins (R4), ctl ignores ce (R2)
    ord = 1'b0;
    step(0, 1, 1, 0, 17'h1_ABC5, "R2 R4 load");
    step(1, 1, 1, 0, 17'h0_0000, "R5 R7 beat1");
    step(1, 1, 1, 0, 17'h0_0000, "R7 beat2");
    step(1, 1, 1, 0, 17'h0_0000, "R7 beat3");
    step(1, 1, 1, 0, 17'h0_0000, "R9 wrap");
    step(1, 1, 1, 1, 17'h1_FFFF, "R6 hold");
    step(1, 0, 1, 1, 17'h0_3333, "R3 gated ignored");
    step(1, 0, 0, 0, 17'h0_0A2E, "R3 cpu load");
    step(1, 1, 1, 0, 17'h0_0000, "R7 beat1 start2");
    step(1, 1, 1, 0, 17'h0_0000, "R7 beat2 start2");
    step(0, 0, 0, 0, 17'h1_2347, "R10 both strobes");
    step(1, 1, 1, 1, 17'h0_0000, "R6 hold after both");

    // interleaved order
    ord = 1'b1;
    step(1, 1, 1, 1, 17'h0_0000, "R8 order switch");
    step(1, 0, 0, 1, 17'h0_F0F3, "R8 load start3");
    step(1, 1, 1, 0, 17'h0_0000, "R8 beat1");
    step(1, 1, 1, 0, 17'h0_0000, "R8 beat2");
    step(1, 1, 1, 0, 17'h0_0000, "R8 beat3");
    step(1, 1, 1, 0, 17'h0_0000, "R9 interleave wrap");
    step(0, 1, 1, 1, 17'h1_5559, "R2 ctl load ce high");
    step(1, 1, 1, 0, 17'h0_0000, "R8 beat1 start1");
    step(1, 1, 1, 0, 17'h0_0000, "R8 beat2 start1");
    step(1, 0, 1, 1, 17'h0_7777, "R3 gated ignored interleave");

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule